// File: doc/BRIEF.md
# Cascadable Dual 8-bit Compare Timer

The block holds two 8-bit up-counters, a low lane and a high lane. Each lane has a compare register and a registered interrupt request. In split mode the lanes are unrelated. Each one counts while its own enable is high. When its count equals its compare value it returns to zero on the next count clock and pulses its request. The interval is therefore the compare value plus one.

In cascade mode the two lanes form one 16-bit counter, and only the low lane's enable runs it. The high lane advances only when the low lane rolls over from FFh to 00h. The compare value is loaded as one 16-bit word. The low request means a full 16-bit match, and that match also clears both lanes. The high request fires on every count clock on which the upper byte alone matches, so software normally masks it in this mode.

The mode select is sampled only while both enables are low. Counting advances on every `clk` cycle in which the relevant enable is high; any prescaling belongs outside the block.

Top module: `dual_timer`

## Requirements
- R1: After a clock edge with `rst_n` low, both counts are 00h, both requests are low, `cascade` is 0 (split mode) and both compare values are FFh.
- R2: In cascade mode `irq_lo` is high for one cycle exactly when, on the previous edge, `en_lo` was high and {`cnt_hi`,`cnt_lo`} equalled the 16-bit compare value.
- R3: In cascade mode `irq_hi` is high in the cycle after any edge at which `en_lo` was high and `cnt_hi` equalled the upper compare byte, whatever the lower byte was.
- R4: In split mode each lane counts under its own enable. It compares against its own compare value, clears to 00h on the edge after a match, and raises its own request in the cycle after the match edge. Neither lane affects the other.
- R5: A lane whose enable is low holds its count, and its request is low in the following cycle. In cascade mode `en_lo` alone runs both lanes and `en_hi` has no effect.
- R6: In cascade mode `cnt_hi` increments only on an edge where `cnt_lo` is FFh and no full match is present; otherwise it holds.
- R7: In cascade mode a full 16-bit match clears both lanes to 00h on that same count edge, so `irq_lo` rises together with the zero count.
- R8: `cascade` takes the value of `mode_sel` only on edges where both `en_lo` and `en_hi` are low; while either enable is high a change on `mode_sel` is ignored.
- R9: `cmp16_we` loads `cmp16_data[15:8]` into the high compare value and `cmp16_data[7:0]` into the low one, in either mode, and wins over a lane write in the same cycle. `cmp_lo_we` and `cmp_hi_we` load their own lane only in split mode and are ignored in cascade mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the count clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 1 | Requested mode: 0 split, 1 cascade |
| en_lo | input | 1 | Low-lane run enable; runs both lanes in cascade |
| en_hi | input | 1 | High-lane run enable (split mode only) |
| cmp_lo_we | input | 1 | Write strobe for the low compare byte |
| cmp_lo_data | input | 8 | Low compare byte |
| cmp_hi_we | input | 1 | Write strobe for the high compare byte |
| cmp_hi_data | input | 8 | High compare byte |
| cmp16_we | input | 1 | Write strobe for the combined 16-bit compare |
| cmp16_data | input | 16 | Combined compare value, high byte in [15:8] |
| irq_lo | output | 1 | Low-lane request (full 16-bit match in cascade) |
| irq_hi | output | 1 | High-lane request (upper-byte match in cascade) |
| cnt_lo | output | 8 | Low-lane count |
| cnt_hi | output | 8 | High-lane count |
| cascade | output | 1 | Current mode, 1 when cascaded |

## Verification
The assertions assume the inputs are steady around each rising edge. They also assume `rst_n` is held low for at least one edge before any property is trusted. The bench changes every input only on the falling edge and starts with three reset edges.

The carry and clear properties assume nothing about the compare value. The cascade stimulus loads a 16-bit compare above any count left over from split mode, so a full match arrives within a few thousand cycles instead of after a full 16-bit wrap.

// File: rtl/dtmr_pkg.sv
// Package: shared types and lane indices for the dual compare timer.
// Assumes: two lanes of equal width; lane 0 is the low byte.
package dtmr_pkg;
    typedef enum logic {
        MODE_SPLIT   = 1'b0,
        MODE_CASCADE = 1'b1
    } tmr_mode_e;

    localparam int LANES   = 2;
    localparam int LANE_LO = 0;
    localparam int LANE_HI = 1;
endpackage

// File: rtl/dtmr_mode_ctl.sv
// Mode register: samples the requested mode only while every lane is stopped.
// Assumes: run_any is high whenever any lane enable is high.
module dtmr_mode_ctl
    import dtmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mode_req,
    input  logic      run_any,
    output tmr_mode_e mode
);
    // Latch the requested mode while idle, otherwise hold it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= MODE_SPLIT;
        else if (!run_any)
            mode <= mode_req ? MODE_CASCADE : MODE_SPLIT;
    end
endmodule

// File: rtl/dtmr_cmp_regs.sv
// Compare registers: per-lane writes in split mode, a combined write in any mode.
// Assumes: the combined write outranks lane writes in the same cycle.
module dtmr_cmp_regs
    import dtmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  tmr_mode_e               mode,
    input  logic [LANES-1:0]        lane_we,
    input  logic [LANES-1:0][W-1:0] lane_wdata,
    input  logic                    wide_we,
    input  logic [LANES*W-1:0]      wide_wdata,
    output logic [LANES-1:0][W-1:0] cmp
);
    for (genvar i = 0; i < LANES; i++) begin : g_reg
        // Update one compare byte from the combined or the lane port.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cmp[i] <= {W{1'b1}};
            else if (wide_we)
                cmp[i] <= wide_wdata[i*W +: W];
            else if (lane_we[i] && mode == MODE_SPLIT)
                cmp[i] <= lane_wdata[i];
        end
    end
endmodule

// File: rtl/dtmr_lane.sv
// One counter lane: clear has priority over increment, wraps naturally.
// Assumes: inc and clr come from the top's sequencing logic.
module dtmr_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt,
    output logic         at_max
);
    // Hold, clear or advance the count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

    assign at_max = (cnt == {W{1'b1}});
endmodule

// File: rtl/dual_timer.sv
// Top: two compare lanes that run split or chained into one double-width timer.
// Assumes: every clk edge is a count clock; requests are one-cycle registered pulses.
module dual_timer
    import dtmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mode_sel,
    input  logic           en_lo,
    input  logic           en_hi,
    input  logic           cmp_lo_we,
    input  logic [W-1:0]   cmp_lo_data,
    input  logic           cmp_hi_we,
    input  logic [W-1:0]   cmp_hi_data,
    input  logic           cmp16_we,
    input  logic [2*W-1:0] cmp16_data,
    output logic           irq_lo,
    output logic           irq_hi,
    output logic [W-1:0]   cnt_lo,
    output logic [W-1:0]   cnt_hi,
    output logic           cascade
);
    tmr_mode_e               mode;
    logic [LANES-1:0][W-1:0] cmp_q;
    logic [LANES-1:0][W-1:0] cnt_q;
    logic [LANES-1:0]        lane_inc, lane_clr, lane_max, lane_hit;
    logic [LANES-1:0]        irq_d;
    logic                    full_hit;
    logic [W-1:0]            cmp_lo_q, cmp_hi_q;

    dtmr_mode_ctl u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_req (mode_sel),
        .run_any  (en_lo | en_hi),
        .mode     (mode)
    );

    dtmr_cmp_regs #(.W(W)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .lane_we    ({cmp_hi_we, cmp_lo_we}),
        .lane_wdata ({cmp_hi_data, cmp_lo_data}),
        .wide_we    (cmp16_we),
        .wide_wdata (cmp16_data),
        .cmp        (cmp_q)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        dtmr_lane #(.W(W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc    (lane_inc[i]),
            .clr    (lane_clr[i]),
            .cnt    (cnt_q[i]),
            .at_max (lane_max[i])
        );
        assign lane_hit[i] = (cnt_q[i] == cmp_q[i]);
    end

    assign full_hit = &lane_hit;

    // Decide per-lane increment, clear and request for this count clock.
    always_comb begin
        if (mode == MODE_CASCADE) begin
            lane_clr[LANE_LO] = en_lo & full_hit;
            lane_clr[LANE_HI] = en_lo & full_hit;
            lane_inc[LANE_LO] = en_lo & ~full_hit;
            lane_inc[LANE_HI] = en_lo & ~full_hit & lane_max[LANE_LO];
            irq_d[LANE_LO]    = en_lo & full_hit;
            irq_d[LANE_HI]    = en_lo & lane_hit[LANE_HI];
        end else begin
            lane_clr[LANE_LO] = en_lo & lane_hit[LANE_LO];
            lane_clr[LANE_HI] = en_hi & lane_hit[LANE_HI];
            lane_inc[LANE_LO] = en_lo & ~lane_hit[LANE_LO];
            lane_inc[LANE_HI] = en_hi & ~lane_hit[LANE_HI];
            irq_d[LANE_LO]    = en_lo & lane_hit[LANE_LO];
            irq_d[LANE_HI]    = en_hi & lane_hit[LANE_HI];
        end
    end

    // Register the match requests as one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_lo <= 1'b0;
            irq_hi <= 1'b0;
        end else begin
            irq_lo <= irq_d[LANE_LO];
            irq_hi <= irq_d[LANE_HI];
        end
    end

    assign cnt_lo   = cnt_q[LANE_LO];
    assign cnt_hi   = cnt_q[LANE_HI];
    assign cascade  = (mode == MODE_CASCADE);
    assign cmp_lo_q = cmp_q[LANE_LO];
    assign cmp_hi_q = cmp_q[LANE_HI];
endmodule

// File: rtl/dtmr_chk.sv
// Checker: temporal properties of the dual timer, bound onto every instance.
// Assumes: inputs settle before each rising edge.
module dtmr_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         casc,
    input logic         en_lo,
    input logic         en_hi,
    input logic [W-1:0] cnt_lo,
    input logic [W-1:0] cnt_hi,
    input logic [W-1:0] cmp_lo,
    input logic [W-1:0] cmp_hi,
    input logic         irq_lo,
    input logic         irq_hi
);
    logic full;
    assign full = ({cnt_hi, cnt_lo} == {cmp_hi, cmp_lo});

    a_r2_full_match_req: assert property (@(posedge clk) disable iff (!rst_n)
        casc && en_lo && full |=> irq_lo);

    a_r3_upper_match_req: assert property (@(posedge clk) disable iff (!rst_n)
        casc && en_lo && (cnt_hi == cmp_hi) |=> irq_hi);

    a_r5_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !en_lo |=> !irq_lo);

    a_r6_carry_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        casc && en_lo && !full && (cnt_lo == {W{1'b1}}) |=> cnt_hi == W'($past(cnt_hi) + 1'b1));

    a_r6_hold_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        casc && en_lo && !full && (cnt_lo != {W{1'b1}}) |=> $stable(cnt_hi));

    a_r7_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
        casc && en_lo && full |=> (cnt_lo == '0) && (cnt_hi == '0));

    a_r8_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
        en_lo || en_hi |=> $stable(casc));

    a_r4_split_hi_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !casc && !en_hi |=> $stable(cnt_hi) && !irq_hi);
endmodule

bind dual_timer dtmr_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .casc   (cascade),
    .en_lo  (en_lo),
    .en_hi  (en_hi),
    .cnt_lo (cnt_lo),
    .cnt_hi (cnt_hi),
    .cmp_lo (cmp_lo_q),
    .cmp_hi (cmp_hi_q),
    .irq_lo (irq_lo),
    .irq_hi (irq_hi)
);

// File: tb/sim_dual_timer.sv
`timescale 1ns/1ps
module sim_dual_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_sel = 1'b0, en_lo = 1'b0, en_hi = 1'b0;
    logic        cmp_lo_we = 1'b0, cmp_hi_we = 1'b0, cmp16_we = 1'b0;
    logic [7:0]  cmp_lo_data = '0, cmp_hi_data = '0;
    logic [15:0] cmp16_data = '0;
    logic        irq_lo, irq_hi, cascade;
    logic [7:0]  cnt_lo, cnt_hi;

    int  n_vec = 0, n_bad = 0;
    bit  live = 0, done = 0;
    int  m_lo, m_hi, m_cl, m_ch;
    bit  m_casc, m_il, m_ih;
    int  lo_pulses = 0;

    always #4 clk = ~clk;

    dual_timer u0 (.*);

    task automatic chk(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: next state from current state and inputs.
    always @(posedge clk) begin
        int nlo, nhi, ncl, nch;
        bit ml, mh, full, il, ih, ncasc;
        if (!rst_n) begin
            m_lo = 0; m_hi = 0; m_cl = 255; m_ch = 255;
            m_casc = 0; m_il = 0; m_ih = 0;
        end else begin
            ml = (m_lo == m_cl); mh = (m_hi == m_ch); full = ml && mh;
            nlo = m_lo; nhi = m_hi;
            if (!m_casc) begin
                if (en_lo) nlo = ml ? 0 : (m_lo + 1) % 256;
                if (en_hi) nhi = mh ? 0 : (m_hi + 1) % 256;
                il = en_lo && ml; ih = en_hi && mh;
            end else begin
                if (en_lo) begin
                    if (full) begin nlo = 0; nhi = 0; end
                    else begin
                        nlo = (m_lo + 1) % 256;
                        if (m_lo == 255) nhi = (m_hi + 1) % 256;
                    end
                end
                il = en_lo && full; ih = en_lo && mh;
            end
            ncl = m_cl; nch = m_ch;
            if (cmp16_we) begin ncl = cmp16_data[7:0]; nch = cmp16_data[15:8]; end
            else if (!m_casc) begin
                if (cmp_lo_we) ncl = cmp_lo_data;
                if (cmp_hi_we) nch = cmp_hi_data;
            end
            ncasc = (!en_lo && !en_hi) ? mode_sel : m_casc;
            m_lo = nlo; m_hi = nhi; m_cl = ncl; m_ch = nch;
            m_il = il; m_ih = ih; m_casc = ncasc;
        end
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (live) begin
            chk(m_casc ? "R2 irq_lo" : "R4 irq_lo", irq_lo, m_il);
            chk(m_casc ? "R3 irq_hi" : "R4 irq_hi", irq_hi, m_ih);
            chk("R5 cnt_lo", cnt_lo, m_lo);
            chk(m_casc ? "R6 cnt_hi" : "R4 cnt_hi", cnt_hi, m_hi);
            chk("R8 cascade", cascade, m_casc);
            if (m_casc && irq_lo) begin
                lo_pulses++;
                chk("R7 clear with request", {cnt_hi, cnt_lo}, 0);
            end
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int hold_lo;
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cnt", {cnt_hi, cnt_lo}, 0);
        chk("R1 irq", {irq_hi, irq_lo}, 0);
        chk("R1 mode", cascade, 0);
        live = 1;
        // R9 lane writes in split mode; R4 independent counting
        cmp_lo_we = 1; cmp_lo_data = 8'd5; cmp_hi_we = 1; cmp_hi_data = 8'd9;
        step(1);
        cmp_lo_we = 0; cmp_hi_we = 0;
        en_lo = 1; en_hi = 1;
        step(40);
        en_hi = 0;
        step(17);
        // R5 stopped lanes hold
        en_lo = 0;
        step(1);
        hold_lo = cnt_lo;
        step(5);
        chk("R5 hold", cnt_lo, hold_lo);
        chk("R5 no request", irq_lo, 0);
        // R8 mode request ignored while running
        en_lo = 1; mode_sel = 1;
        step(6);
        chk("R8 ignored", cascade, 0);
        en_lo = 0;
        step(2);
        chk("R8 taken", cascade, 1);
        // R9 combined write, lane write ignored in cascade
        cmp16_we = 1; cmp16_data = 16'h0A03;
        step(1);
        cmp16_we = 0; cmp_lo_we = 1; cmp_lo_data = 8'h10;
        step(1);
        cmp_lo_we = 0;
        // R2 R3 R6 R7 cascade run, en_hi has no effect
        en_lo = 1;
        step(1500);
        en_hi = 1;
        step(4000);
        chk("R2 full-match pulses seen", lo_pulses >= 2, 1);
        en_lo = 0; en_hi = 0; mode_sel = 0;
        step(2);
        chk("R8 back to split", cascade, 0);
        // R4 split with random enables and live compare writes
        cmp_lo_we = 1; cmp_lo_data = 8'd0; cmp_hi_we = 1; cmp_hi_data = 8'd3;
        step(1);
        cmp_lo_we = 0; cmp_hi_we = 0;
        for (int i = 0; i < 400; i++) begin
            en_lo = 1'($urandom_range(0, 3) != 0);
            en_hi = 1'($urandom_range(0, 1));
            if (i % 50 == 25) begin
                cmp_hi_we = 1; cmp_hi_data = 8'($urandom_range(1, 12));
            end else cmp_hi_we = 0;
            step(1);
        end
        en_lo = 0; en_hi = 0; cmp_hi_we = 0;
        step(3);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule